// File: doc/BRIEF.md
# PLL lock and bandwidth controller

This block supervises a clock-generator PLL from the digital side. It counts VCO edge strobes across a measuring window of a fixed number of reference-clock strobes. It compares each finished count against an expected value, and from that it chooses whether the loop filter runs in its wide acquisition setting or its narrow tracking setting. It also keeps a lock flag, raises a sticky interrupt when lock changes, and reports whether the VCO may be chosen as the base clock.

The block has two modes. In automatic mode the hardware drives the filter mode and the lock flag from the measurements, and software can only read them. In manual mode software writes the filter mode directly. The lock flag is then held low and no interrupt is raised, and software vouches for VCO safety through its own input. Software must keep the manual filter bit at acquisition when it switches the PLL on. It sets tracking only after the acquisition wait, and selects the VCO only after the further settle wait. The block does not time these waits. Clearing the enable returns the measurement and the filter to their start state.

All inputs are synchronous to `clk`. `ref_tick` and `vco_tick` are one-cycle strobes already brought into that domain.

Top module: `pll_lock_supervisor`

## Requirements
- R1: In automatic mode, when a window of REF_PER_WIN (16) reference strobes closes, `filter_track` becomes 1 if the VCO strobe count is within EXP_COUNT (64) ± ACQ_BAND (8), bounds inclusive, and 0 otherwise. The count includes a VCO strobe in the same cycle as the closing reference strobe. The output changes on the second clock edge after that closing strobe.
- R2: In automatic mode, `lock` rises only after LOCK_WINS (2) consecutive windows whose count lies within EXP_COUNT ± LOCK_BAND (2), bounds inclusive. It falls on the first window outside that band.
- R3: In automatic mode with `irq_en` = 1, every rise or fall of `lock` sets `irq_pending`. The flag stays set until it is acknowledged.
- R4: A cycle with `irq_ack` = 1 clears `irq_pending`. If a lock change falls in the same cycle as the acknowledge, the set wins and the flag stays 1.
- R5: In manual mode (`auto_mode` = 0), `filter_track` equals `track_wr` from the previous cycle. `lock` is 0, and no interrupt is set, even when lock is dropped by leaving automatic mode.
- R6: With `enable` = 0, `filter_track` and `lock` become 0 on the next edge and no interrupt is set. The window count and the lock streak restart from zero, so a partial window and earlier good windows do not carry over.
- R7: `vco_safe` equals `lock` in automatic mode and `sw_safe` in manual mode. `base_sel_vco` is `clk_sel` AND `vco_safe`.
- R8: With `irq_en` = 0, lock changes leave `irq_pending` unchanged.
- R9: After reset, `filter_track`, `lock` and `irq_pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | PLL on; 0 restarts measurement and filter |
| auto_mode | input | 1 | 1 = hardware controls filter and lock, 0 = software controls filter |
| irq_en | input | 1 | Allows lock changes to set the interrupt |
| track_wr | input | 1 | Manual filter mode written by software, 1 = tracking |
| clk_sel | input | 1 | Software request to use the VCO as base clock |
| sw_safe | input | 1 | Software-asserted VCO safety, used in manual mode |
| irq_ack | input | 1 | Write-one-to-clear strobe for the interrupt |
| ref_tick | input | 1 | Reference clock strobe |
| vco_tick | input | 1 | VCO clock strobe |
| filter_track | output | 1 | Filter mode, 1 = tracking, 0 = acquisition |
| lock | output | 1 | Lock flag |
| irq_pending | output | 1 | Sticky interrupt request |
| vco_safe | output | 1 | VCO may be used as base clock |
| base_sel_vco | output | 1 | Gated base-clock select |

## Verification
A lock change and a software acknowledge of the interrupt can meet in the same cycle. The bench provokes this by pulsing `irq_ack` exactly on the edge where the FSM consumes a window result. It does this once when the lock flag stays put, where the flag must clear, and once when lock rises, where the flag must stay set. A second meeting point is leaving automatic mode while locked: the lock drop and the interrupt suppression land on one edge, and the bench checks that the flag stays clear.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;

   typedef enum logic {
      FLT_ACQ   = 1'b0,
      FLT_TRACK = 1'b1
   } flt_mode_e;

   // number of bands judged per window: acquisition and lock
   localparam int NUM_BANDS = 2;
   localparam int BAND_ACQ  = 0;
   localparam int BAND_LOCK = 1;

endpackage

// File: rtl/pll_win_counter.sv
module pll_win_counter #(
   parameter int REF_PER_WIN = 16,
   parameter int CNT_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             ref_tick,
   input  logic             vco_tick,
   output logic             win_valid,
   output logic [CNT_W-1:0] win_count
);

   localparam int REF_W = (REF_PER_WIN > 1) ? $clog2(REF_PER_WIN) : 1;
   localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_PER_WIN - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   generate
      if (REF_PER_WIN < 2) begin : g_bad_win
         $error("REF_PER_WIN must be at least 2");
      end
   endgenerate

   logic [REF_W-1:0] ref_cnt;
   logic [CNT_W-1:0] vco_cnt;
   logic [CNT_W-1:0] vco_next;

   // saturating VCO count including this cycle's strobe
   always_comb begin
      vco_next = vco_cnt;
      if (vco_tick && (vco_cnt != CNT_MAX)) vco_next = vco_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_cnt   <= '0;
         vco_cnt   <= '0;
         win_valid <= 1'b0;
         win_count <= '0;
      end else if (!enable) begin
         ref_cnt   <= '0;
         vco_cnt   <= '0;
         win_valid <= 1'b0;
      end else begin
         win_valid <= 1'b0;
         if (ref_tick && (ref_cnt == REF_LAST)) begin
            win_valid <= 1'b1;
            win_count <= vco_next;
            vco_cnt   <= '0;
            ref_cnt   <= '0;
         end else begin
            vco_cnt <= vco_next;
            if (ref_tick) ref_cnt <= ref_cnt + 1'b1;
         end
      end
   end

   // R1
   win_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |=> !win_valid)
      else $error("window result lasted more than one cycle");

endmodule

// File: rtl/pll_band_judge.sv
module pll_band_judge #(
   parameter int CNT_W     = 8,
   parameter int EXP_COUNT = 64,
   parameter int BAND      = 8
) (
   input  logic [CNT_W-1:0] count,
   output logic             in_band
);

   localparam int LO = EXP_COUNT - BAND;
   localparam int HI = EXP_COUNT + BAND;
   localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO);
   localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI);

   generate
      if (BAND > EXP_COUNT) begin : g_bad_lo
         $error("band wider than expected count");
      end
      if (HI >= (1 << CNT_W) - 1) begin : g_bad_hi
         $error("count width too small for band");
      end
   endgenerate

   always_comb in_band = (count >= LO_V) && (count <= HI_V);

endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
   import pll_sup_pkg::*;
#(
   parameter int LOCK_WINS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic auto_mode,
   input  logic irq_en,
   input  logic track_wr,
   input  logic irq_ack,
   input  logic win_valid,
   input  logic acq_ok,
   input  logic lock_ok,
   output logic filter_track,
   output logic lock,
   output logic irq_pending
);

   localparam int SW = $clog2(LOCK_WINS + 1);
   localparam logic [SW-1:0] STREAK_FULL = SW'(LOCK_WINS);

   generate
      if (LOCK_WINS < 1) begin : g_bad_wins
         $error("LOCK_WINS must be at least 1");
      end
   endgenerate

   flt_mode_e       mode_q, mode_nxt;
   logic [SW-1:0]   streak_q, streak_nxt;
   logic            lock_q, lock_nxt;
   logic            pend_q, pend_nxt;
   logic            irq_set;

   always_comb begin
      mode_nxt   = mode_q;
      streak_nxt = streak_q;
      lock_nxt   = lock_q;
      if (!enable) begin
         mode_nxt   = FLT_ACQ;
         streak_nxt = '0;
         lock_nxt   = 1'b0;
      end else if (!auto_mode) begin
         mode_nxt   = track_wr ? FLT_TRACK : FLT_ACQ;
         streak_nxt = '0;
         lock_nxt   = 1'b0;
      end else if (win_valid) begin
         mode_nxt = acq_ok ? FLT_TRACK : FLT_ACQ;
         if (lock_ok) begin
            streak_nxt = (streak_q == STREAK_FULL) ? streak_q : streak_q + 1'b1;
            lock_nxt   = (streak_nxt == STREAK_FULL);
         end else begin
            streak_nxt = '0;
            lock_nxt   = 1'b0;
         end
      end
   end

   // lock changes are reported only while hardware owns the flag
   always_comb begin
      irq_set  = enable && auto_mode && irq_en && (lock_nxt != lock_q);
      pend_nxt = pend_q;
      if (irq_set)      pend_nxt = 1'b1;
      else if (irq_ack) pend_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= FLT_ACQ;
         streak_q <= '0;
         lock_q   <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         mode_q   <= mode_nxt;
         streak_q <= streak_nxt;
         lock_q   <= lock_nxt;
         pend_q   <= pend_nxt;
      end
   end

   assign filter_track = (mode_q == FLT_TRACK);
   assign lock         = lock_q;
   assign irq_pending  = pend_q;

   // R2
   lock_rise_on_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(win_valid))
      else $error("lock rose without a window result");

   // R3
   irq_follows_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> (lock_q != $past(lock_q)))
      else $error("interrupt set without a lock change");

   // R5
   manual_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mode |=> !lock_q)
      else $error("lock seen in manual mode");

   // R6
   disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!lock_q && (mode_q == FLT_ACQ)))
      else $error("disable did not clear lock and filter");

endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
   import pll_sup_pkg::*;
#(
   parameter int REF_PER_WIN = 16,
   parameter int EXP_COUNT   = 64,
   parameter int ACQ_BAND    = 8,
   parameter int LOCK_BAND   = 2,
   parameter int LOCK_WINS   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic auto_mode,
   input  logic irq_en,
   input  logic track_wr,
   input  logic clk_sel,
   input  logic sw_safe,
   input  logic irq_ack,
   input  logic ref_tick,
   input  logic vco_tick,
   output logic filter_track,
   output logic lock,
   output logic irq_pending,
   output logic vco_safe,
   output logic base_sel_vco
);

   localparam int CNT_W = $clog2(EXP_COUNT + ACQ_BAND + 1) + 1;

   generate
      if (LOCK_BAND > ACQ_BAND) begin : g_bad_bands
         $error("lock band must not exceed acquisition band");
      end
   endgenerate

   logic             win_valid;
   logic [CNT_W-1:0] win_count;
   logic [NUM_BANDS-1:0] in_band;

   pll_win_counter #(
      .REF_PER_WIN (REF_PER_WIN),
      .CNT_W       (CNT_W)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .ref_tick  (ref_tick),
      .vco_tick  (vco_tick),
      .win_valid (win_valid),
      .win_count (win_count)
   );

   for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
      pll_band_judge #(
         .CNT_W     (CNT_W),
         .EXP_COUNT (EXP_COUNT),
         .BAND      ((g == BAND_ACQ) ? ACQ_BAND : LOCK_BAND)
      ) u_judge (
         .count   (win_count),
         .in_band (in_band[g])
      );
   end

   pll_lock_ctrl #(
      .LOCK_WINS (LOCK_WINS)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .auto_mode    (auto_mode),
      .irq_en       (irq_en),
      .track_wr     (track_wr),
      .irq_ack      (irq_ack),
      .win_valid    (win_valid),
      .acq_ok       (in_band[BAND_ACQ]),
      .lock_ok      (in_band[BAND_LOCK]),
      .filter_track (filter_track),
      .lock         (lock),
      .irq_pending  (irq_pending)
   );

   assign vco_safe     = auto_mode ? lock : sw_safe;
   assign base_sel_vco = clk_sel & vco_safe;

endmodule

// File: tb/sim_pll_lock_supervisor.sv
module sim_pll_lock_supervisor;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, auto_mode = 1'b1, irq_en = 1'b0, track_wr = 1'b0;
   logic clk_sel = 1'b0, sw_safe = 1'b0, irq_ack = 1'b0;
   logic ref_tick = 1'b0, vco_tick = 1'b0;
   logic filter_track, lock, irq_pending, vco_safe, base_sel_vco;

   always #4 clk = ~clk;

   pll_lock_supervisor u0 (
      .clk (clk), .rst_n (rst_n), .enable (enable), .auto_mode (auto_mode),
      .irq_en (irq_en), .track_wr (track_wr), .clk_sel (clk_sel),
      .sw_safe (sw_safe), .irq_ack (irq_ack), .ref_tick (ref_tick),
      .vco_tick (vco_tick), .filter_track (filter_track), .lock (lock),
      .irq_pending (irq_pending), .vco_safe (vco_safe),
      .base_sel_vco (base_sel_vco)
   );

   typedef struct {
      bit    tr;
      bit    lk;
      bit    ir;
      bit    sf;
      bit    bs;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // bench model state
   bit m_track = 0, m_lock = 0, m_pend = 0;
   int m_streak = 0;

   task automatic push_exp(input string tag);
      exp_t e;
      bit safe;
      safe  = auto_mode ? m_lock : sw_safe;
      e.tr  = m_track;
      e.lk  = m_lock;
      e.ir  = m_pend;
      e.sf  = safe;
      e.bs  = clk_sel & safe;
      e.tag = tag;
      q.push_back(e);
      #1;
   endtask

   task automatic cmp(input string tag, input string fld, input bit act, input bit exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, fld, act, exp);
      end
   endtask

   // monitor: pops expected items and compares the outputs
   initial begin
      forever begin
         wait (q.size() != 0);
         begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "filter_track", filter_track, e.tr);
            cmp(e.tag, "lock",         lock,         e.lk);
            cmp(e.tag, "irq_pending",  irq_pending,  e.ir);
            cmp(e.tag, "vco_safe",     vco_safe,     e.sf);
            cmp(e.tag, "base_sel_vco", base_sel_vco, e.bs);
         end
      end
   end

   // one window of 16 reference strobes (every 8 cycles), k VCO strobes
   task automatic run_window(input int k, input bit ack_mid, input string tag);
      int  d;
      bit  nl;
      for (int i = 0; i < 128; i++) begin
         @(negedge clk);
         ref_tick = ((i % 8) == 7);
         vco_tick = (i < k);
      end
      @(negedge clk);
      ref_tick = 1'b0;
      vco_tick = 1'b0;
      irq_ack  = ack_mid;
      @(negedge clk);
      irq_ack  = 1'b0;
      if (enable && auto_mode) begin
         d = (k > 64) ? k - 64 : 64 - k;
         m_track = (d <= 8);
         if (d <= 2) m_streak = (m_streak >= 2) ? 2 : m_streak + 1;
         else        m_streak = 0;
         nl = (m_streak >= 2);
         if (nl != m_lock && irq_en) m_pend = 1;
         else if (ack_mid)           m_pend = 0;
         m_lock = nl;
      end else if (ack_mid) begin
         m_pend = 0;
      end
      push_exp(tag);
   endtask

   task automatic ack_irq(input string tag);
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      m_pend = 0;
      push_exp(tag);
   endtask

   task automatic go_manual(input string tag);
      @(negedge clk);
      auto_mode = 1'b0;
      @(negedge clk);
      m_lock = 0;
      m_streak = 0;
      m_track = track_wr;
      push_exp(tag);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      push_exp("R9 reset state");

      enable = 1'b1;
      irq_en = 1'b1;
      clk_sel = 1'b1;
      run_window(90, 0, "R1 far out of band");
      run_window(72, 0, "R1 upper acq bound");
      run_window(73, 0, "R1 just above acq band");
      run_window(56, 0, "R1 lower acq bound");
      run_window(55, 0, "R1 just below acq band");
      run_window(66, 0, "R2 first lock window");
      run_window(62, 0, "R2 R3 R7 second lock window");
      run_window(64, 0, "R3 pending sticky");
      ack_irq("R4 ack clears");
      run_window(67, 0, "R2 R3 lock drop");
      run_window(64, 1, "R4 ack without lock change");
      run_window(64, 1, "R4 set beats ack");

      irq_en = 1'b0;
      ack_irq("R4 ack before disable of irq");
      run_window(90, 0, "R8 lock drop masked");
      irq_en = 1'b1;
      run_window(64, 0, "R2 relock first");
      run_window(64, 0, "R3 relock");
      ack_irq("R4 ack");

      sw_safe = 1'b1;
      track_wr = 1'b0;
      go_manual("R5 R7 manual drops lock silently");
      @(negedge clk);
      track_wr = 1'b1;
      @(negedge clk);
      m_track = 1;
      push_exp("R5 manual track write");
      run_window(64, 0, "R5 manual window ignored");
      sw_safe = 1'b0;
      @(negedge clk);
      push_exp("R7 manual safe cleared");

      @(negedge clk);
      auto_mode = 1'b1;
      @(negedge clk);
      push_exp("R7 back to auto");
      run_window(64, 0, "R2 auto first");
      run_window(64, 0, "R3 auto relock");
      ack_irq("R4 ack");

      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      m_lock = 0;
      m_track = 0;
      m_streak = 0;
      push_exp("R6 disable clears");
      @(negedge clk);
      enable = 1'b1;
      run_window(64, 0, "R6 streak restarted");
      // partial window, then disable: the partial count must be discarded
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         ref_tick = ((i % 8) == 7);
         vco_tick = 1'b1;
      end
      @(negedge clk);
      ref_tick = 1'b0;
      vco_tick = 1'b0;
      enable = 1'b0;
      @(negedge clk);
      m_lock = 0;
      m_track = 0;
      m_streak = 0;
      enable = 1'b1;
      run_window(60, 0, "R6 partial window discarded");

      wait (q.size() == 0);
      #10;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule